// File: doc/BRIEF.md
# Chainable Reload Down-Counter Timer

This block is a programmable timer built from two 8-bit down counters. Each counter has its own reload register. The two counters can run as independent 8-bit timers. Setting a mode bit chains them into a single 16-bit down counter, with counter 0 as the low byte and counter 1 as the high byte. The count clock comes from outside as a one-cycle tick per counter, so the block has no prescaler.

Software reaches the block through a small byte-wide register port. That port covers the reload values, the control bits (run 0, run 1, chain mode, pulse-output enable), write-one strobes and counter readback. Underflows reload the counters, set a sticky interrupt request and drive two toggle flops. The first toggle flop gives a gated pulse output. The second gives a serial-interface clock at half the underflow rate.

Register addresses: 0 reload 0, 1 reload 1, 2 control, 3 strobes (write-only), 4 counter 0 data, 5 counter 1 data. Control bits: bit 0 run 0, bit 1 run 1, bit 2 chain mode, bit 3 pulse-output enable. Strobe bits: bit 0 load counter 0, bit 1 load counter 1, bit 2 clear interrupt.

Top module: `chain_reload_timer`

## Requirements
- R1: After reset the counters, reload registers and control bits read 0, and `irq`, `pulse_out`, `sclk_out`, `uflow0` and `uflow1` are 0.
- R2: Writing 1 to strobe bit 0 (address 3) copies reload 0 into counter 0, and strobe bit 1 does the same for counter 1. This load wins over a count tick in the same cycle.
- R3: In 8-bit mode (control bit 2 = 0), a counter whose run bit is set steps down once per tick on its own tick input. When it is at 0x00, the tick reloads it and pulses its `uflowN` high for one cycle. With reload N, an underflow comes every N+1 ticks, and reload 0x00 is legal.
- R4: With the run bit cleared, ticks leave the counter value unchanged. Setting the run bit again resumes counting from the held value.
- R5: In chain mode, the low byte steps on each `tick0` while run 0 is set. The high byte steps only on a tick where the low byte borrows from 0x00 to 0xFF. `tick1` and run 1 have no effect.
- R6: In chain mode, a tick with both bytes at 0x00 loads both reload values and pulses `uflow1` for one cycle. `uflow0` stays 0.
- R7: In chain mode, reading address 4 captures the high byte, and a later read of address 5 returns that captured value. In 8-bit mode, address 5 returns the live counter 1 value.
- R8: Every underflow sets the sticky `irq`. Writing 1 to strobe bit 2 clears it.
- R9: `sclk_out` toggles on every timer 1 underflow (the 16-bit underflow in chain mode), whatever the pulse-output enable is set to.
- R10: `pulse_out` is a toggle flop that flips on each timer 1 underflow, gated by control bit 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick0 | input | 1 | Count tick for counter 0 |
| tick1 | input | 1 | Count tick for counter 1 (8-bit mode) |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_en | input | 1 | Register read strobe (drives capture) |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 8 | Combinational read data |
| uflow0 | output | 1 | Counter 0 underflow pulse (8-bit mode) |
| uflow1 | output | 1 | Counter 1 or 16-bit underflow pulse |
| irq | output | 1 | Sticky interrupt request |
| pulse_out | output | 1 | Gated toggle output |
| sclk_out | output | 1 | Serial clock, half of timer 1 underflow rate |

## Verification
The embedded assertions check on every cycle that:
- an idle counter holds its value;
- an underflow reloads the counters;
- the chained high byte stays put unless the low byte borrows;
- every underflow sets `irq`;
- `sclk_out` flips on each timer 1 underflow.

Some behaviour needs a sequence of register accesses and ticks, so only the bench scenarios can show it:
- the strobe-over-tick priority;
- the N+1 tick period;
- stop and resume;
- the full 0x0101 chained count through its borrow;
- the low-first read with a held high byte;
- the pulse-enable gating.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        A_RLD0 = 3'd0,
        A_RLD1 = 3'd1,
        A_CTRL = 3'd2,
        A_STRB = 3'd3,
        A_CNT0 = 3'd4,
        A_CNT1 = 3'd5
    } reg_addr_e;

    typedef struct packed {
        logic pout_en;
        logic mode16;
        logic run1;
        logic run0;
    } ctrl_t;

    typedef struct packed {
        logic ev_lo;
        logic ev_hi;
    } uf_ev_t;

    function automatic logic is_zero(input logic [BYTE_W-1:0] v);
        return v == '0;
    endfunction
endpackage

// File: rtl/tmr_byte_counter.sv
module tmr_byte_counter #(
    parameter int W = tmr_pkg::BYTE_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic         dec,
    input  logic [W-1:0] reload_val,
    output logic [W-1:0] cnt,
    output logic         zero
);
    always_ff @(posedge clk) begin
        if (rst)       cnt <= '0;
        else if (load) cnt <= reload_val;
        else if (dec)  cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);

    // R4
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (!load && !dec) |=> $stable(cnt));
endmodule

// File: rtl/tmr_events.sv
module tmr_events
    import tmr_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  uf_ev_t ev,
    input  logic   irq_clr,
    input  logic   pout_en,
    output logic   uflow0,
    output logic   uflow1,
    output logic   irq,
    output logic   pulse_out,
    output logic   sclk_out
);
    logic tog_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            uflow0   <= 1'b0;
            uflow1   <= 1'b0;
            irq      <= 1'b0;
            tog_q    <= 1'b0;
            sclk_out <= 1'b0;
        end else begin
            uflow0 <= ev.ev_lo;
            uflow1 <= ev.ev_hi;
            if (ev.ev_lo || ev.ev_hi) irq <= 1'b1;
            else if (irq_clr)         irq <= 1'b0;
            if (ev.ev_hi) begin
                tog_q    <= ~tog_q;
                sclk_out <= ~sclk_out;
            end
        end
    end

    assign pulse_out = tog_q & pout_en;

    // R8
    irq_set_chk: assert property (@(posedge clk) disable iff (rst)
        (ev.ev_lo || ev.ev_hi) |=> irq);
    // R9
    sclk_toggle_chk: assert property (@(posedge clk) disable iff (rst)
        ev.ev_hi |=> (sclk_out != $past(sclk_out)));
    // R10
    tog_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !ev.ev_hi |=> $stable(tog_q));
endmodule

// File: rtl/tmr_readback.sv
module tmr_readback
    import tmr_pkg::*;
#(
    parameter int W = BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    input  ctrl_t             ctrl,
    input  logic [W-1:0]      rld0,
    input  logic [W-1:0]      rld1,
    input  logic [W-1:0]      cnt0,
    input  logic [W-1:0]      cnt1,
    output logic [W-1:0]      rd_data
);
    logic [W-1:0] hi_hold;
    logic         cap;

    assign cap = rd_en && (rd_addr == A_CNT0) && ctrl.mode16;

    always_ff @(posedge clk) begin
        if (rst)      hi_hold <= '0;
        else if (cap) hi_hold <= cnt1;
    end

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            A_RLD0: rd_data = rld0;
            A_RLD1: rd_data = rld1;
            A_CTRL: rd_data = W'(ctrl);
            A_CNT0: rd_data = cnt0;
            A_CNT1: rd_data = ctrl.mode16 ? hi_hold : cnt1;
            default: rd_data = '0;
        endcase
    end

    // R7
    hold_capture_chk: assert property (@(posedge clk) disable iff (rst)
        cap |=> hi_hold == $past(cnt1));
endmodule

// File: rtl/chain_reload_timer.sv
module chain_reload_timer
    import tmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick0,
    input  logic              tick1,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [BYTE_W-1:0] rd_data,
    output logic              uflow0,
    output logic              uflow1,
    output logic              irq,
    output logic              pulse_out,
    output logic              sclk_out
);
    localparam int NCNT = 2;

    ctrl_t             ctrl_q;
    logic [BYTE_W-1:0] rld_q [NCNT];
    logic [BYTE_W-1:0] cnt   [NCNT];
    logic [NCNT-1:0]   zero, load, dec, strb_ld, run, tick;
    logic              irq_clr, step16, both_zero, uf16;
    logic [NCNT-1:0]   dec8, uf8;
    uf_ev_t            ev;
    logic              unused_wr_hi;

    assign unused_wr_hi = ^wr_data[BYTE_W-1:4];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            rld_q[0] <= '0;
            rld_q[1] <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                A_RLD0: rld_q[0] <= wr_data;
                A_RLD1: rld_q[1] <= wr_data;
                A_CTRL: ctrl_q   <= ctrl_t'(wr_data[3:0]);
                default: ;
            endcase
        end
    end

    assign strb_ld = (wr_en && wr_addr == A_STRB) ? wr_data[1:0] : 2'b00;
    assign irq_clr = wr_en && (wr_addr == A_STRB) && wr_data[2];
    assign run     = {ctrl_q.run1, ctrl_q.run0};
    assign tick    = {tick1, tick0};

    assign step16    = ctrl_q.mode16 && ctrl_q.run0 && tick0;
    assign both_zero = zero[0] && zero[1];
    assign uf16      = step16 && both_zero && !strb_ld[0] && !strb_ld[1];

    for (genvar i = 0; i < NCNT; i++) begin : g_cnt
        assign dec8[i] = !ctrl_q.mode16 && run[i] && tick[i];
        assign uf8[i]  = dec8[i] && zero[i] && !strb_ld[i];
        assign load[i] = strb_ld[i] ||
                         (ctrl_q.mode16 ? (step16 && both_zero) : (dec8[i] && zero[i]));
        tmr_byte_counter #(.W(BYTE_W)) u_cnt (
            .clk       (clk),
            .rst       (rst),
            .load      (load[i]),
            .dec       (dec[i]),
            .reload_val(rld_q[i]),
            .cnt       (cnt[i]),
            .zero      (zero[i])
        );
    end

    assign dec[0] = ctrl_q.mode16 ? step16 : dec8[0];
    assign dec[1] = ctrl_q.mode16 ? (step16 && zero[0]) : dec8[1];

    assign ev.ev_lo = !ctrl_q.mode16 && uf8[0];
    assign ev.ev_hi = ctrl_q.mode16 ? uf16 : uf8[1];

    tmr_events u_ev (
        .clk      (clk),
        .rst      (rst),
        .ev       (ev),
        .irq_clr  (irq_clr),
        .pout_en  (ctrl_q.pout_en),
        .uflow0   (uflow0),
        .uflow1   (uflow1),
        .irq      (irq),
        .pulse_out(pulse_out),
        .sclk_out (sclk_out)
    );

    tmr_readback #(.W(BYTE_W)) u_rb (
        .clk    (clk),
        .rst    (rst),
        .rd_en  (rd_en),
        .rd_addr(rd_addr),
        .ctrl   (ctrl_q),
        .rld0   (rld_q[0]),
        .rld1   (rld_q[1]),
        .cnt0   (cnt[0]),
        .cnt1   (cnt[1]),
        .rd_data(rd_data)
    );

    // R6
    full_reload_chk: assert property (@(posedge clk) disable iff (rst)
        uf16 |=> (cnt[0] == $past(rld_q[0])) && (cnt[1] == $past(rld_q[1])));
    // R3
    reload_8b_chk: assert property (@(posedge clk) disable iff (rst)
        uf8[0] && !ctrl_q.mode16 |=> cnt[0] == $past(rld_q[0]));
    // R5
    hi_borrow_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.mode16 && !zero[0] && !strb_ld[1]) |=> $stable(cnt[1]));
    // R6
    lo_quiet_chain_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.mode16 && $past(ctrl_q.mode16)) |-> !uflow0);
endmodule

// File: tb/tb_chain_reload_timer.sv
module tb_chain_reload_timer;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick0 = 0, tick1 = 0, wr_en = 0, rd_en = 0;
    logic [2:0] wr_addr = '0, rd_addr = '0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       uflow0, uflow1, irq, pulse_out, sclk_out;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    typedef struct {
        int    sel;
        int    exp;
        string req;
    } item_t;
    item_t sb_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    chain_reload_timer dut (
        .clk(clk), .rst(rst), .tick0(tick0), .tick1(tick1),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .uflow0(uflow0), .uflow1(uflow1), .irq(irq),
        .pulse_out(pulse_out), .sclk_out(sclk_out)
    );

    // sel: 0 rd_data, 1 uflow0, 2 uflow1, 3 irq, 4 pulse_out, 5 sclk_out
    function automatic int observe(int sel);
        case (sel)
            0: return int'(rd_data);
            1: return int'(uflow0);
            2: return int'(uflow1);
            3: return int'(irq);
            4: return int'(pulse_out);
            default: return int'(sclk_out);
        endcase
    endfunction

    initial begin : monitor
        forever begin
            item_t it;
            wait (sb_q.size() != 0);
            it = sb_q.pop_front();
            checks++;
            if (observe(it.sel) !== it.exp) begin
                failures++;
                $display("FAIL %s sel=%0d actual=0x%0h expected=0x%0h",
                         it.req, it.sel, observe(it.sel), it.exp);
            end
        end
    end

    task automatic expect_val(int sel, int exp, string req);
        item_t it;
        it.sel = sel; it.exp = exp; it.req = req;
        sb_q.push_back(it);
        wait (sb_q.size() == 0);
    endtask

    task automatic wr(logic [2:0] a, logic [7:0] d);
        wr_en = 1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic tk(logic t0, logic t1);
        tick0 = t0; tick1 = t1;
        @(negedge clk);
        tick0 = 0; tick1 = 0;
    endtask

    task automatic rd_check(logic [2:0] a, int exp, string req);
        rd_en = 1; rd_addr = a;
        #1;
        expect_val(0, exp, req);
        @(negedge clk);
        rd_en = 0;
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 150000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : driver
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        rd_check(3'd4, 0, "R1");
        rd_check(3'd2, 0, "R1");
        expect_val(3, 0, "R1");
        expect_val(5, 0, "R1");
        expect_val(4, 0, "R1");

        // R2 load strobe, then priority over tick
        wr(3'd0, 8'd5);
        wr(3'd3, 8'h01);
        rd_check(3'd4, 5, "R2");
        wr(3'd2, 8'h01);
        tk(1, 0);
        rd_check(3'd4, 4, "R2");
        tick0 = 1;
        wr(3'd3, 8'h01);
        tick0 = 0;
        rd_check(3'd4, 5, "R2");

        // R3 period of N+1 with reload 2
        wr(3'd0, 8'd2);
        wr(3'd3, 8'h01);
        tk(1, 0);
        tk(1, 0);
        expect_val(1, 0, "R3");
        tk(1, 0);
        expect_val(1, 1, "R3");
        expect_val(3, 1, "R8");
        @(negedge clk);
        expect_val(1, 0, "R3");
        rd_check(3'd4, 2, "R3");

        // R4 stop holds, restart resumes
        wr(3'd2, 8'h00);
        for (int i = 0; i < 3; i++) tk(1, 0);
        rd_check(3'd4, 2, "R4");
        wr(3'd2, 8'h01);
        tk(1, 0);
        rd_check(3'd4, 1, "R4");

        // R8 clear interrupt
        wr(3'd3, 8'h04);
        expect_val(3, 0, "R8");

        // R9 / R10 timer 1 with reload 0
        wr(3'd2, 8'h02);
        wr(3'd3, 8'h02);
        tk(0, 1);
        expect_val(5, 1, "R9");
        expect_val(2, 1, "R3");
        expect_val(4, 0, "R10");
        wr(3'd2, 8'h0A);
        expect_val(4, 1, "R10");
        tk(0, 1);
        expect_val(5, 0, "R9");
        expect_val(4, 0, "R10");

        // R5 / R6 chained mode, reload 0x0101
        wr(3'd2, 8'h07);
        wr(3'd4 - 3'd4, 8'h01);
        wr(3'd1, 8'h01);
        wr(3'd3, 8'h03);
        wr(3'd3, 8'h04);
        tk(1, 0);
        rd_check(3'd4, 8'h00, "R5");
        rd_check(3'd5, 8'h01, "R5");
        tk(1, 0);
        rd_check(3'd4, 8'hFF, "R5");
        rd_check(3'd5, 8'h00, "R5");
        tk(0, 1);
        rd_check(3'd4, 8'hFF, "R5");
        for (int i = 0; i < 255; i++) tk(1, 0);
        rd_check(3'd4, 8'h00, "R5");
        rd_check(3'd5, 8'h00, "R5");
        expect_val(3, 0, "R6");
        tk(1, 0);
        expect_val(2, 1, "R6");
        expect_val(1, 0, "R6");
        expect_val(3, 1, "R8");
        expect_val(5, 1, "R9");
        rd_check(3'd4, 8'h01, "R6");
        rd_check(3'd5, 8'h01, "R6");

        // R7 hold latch: read low first, high held across a borrow
        rd_check(3'd4, 8'h01, "R7");
        tk(1, 0);
        tk(1, 0);
        rd_check(3'd5, 8'h01, "R7");
        rd_check(3'd4, 8'hFF, "R7");
        rd_check(3'd5, 8'h00, "R7");
        wr(3'd2, 8'h00);
        rd_check(3'd5, 8'h00, "R7");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule